// File: doc/BRIEF.md
# Privileged Time-Slice Countdown Timer

This block keeps the operating system in charge of the processor by counting down a time slice and raising an interrupt request when the slice runs out. Privileged software writes a starting count through a load port. The count drops by one on each cycle in which the tick enable is high. When the count reaches zero, a level interrupt request goes to the interrupt entry logic and stays there until it is acknowledged or the timer is loaded again.

A load is accepted only when the processor is in monitor mode. A load issued in user mode does not change the counter. Instead it produces a one-cycle privilege-violation pulse, so that the fault logic can trap the offending program.

Alongside the countdown, a free-running 32-bit elapsed-tick counter advances on every tick. Mode and loads have no effect on it. It gives the system a time base for working out the current time.

Top module: `slice_timer`

## Requirements
- R1: After a synchronous active-low reset, the outputs are in this state: `count_o` is 0, `irq_o` is 0, `priv_err_o` is 0 and `elapsed_o` is 0. The timer is disarmed, so ticks at a count of zero raise no interrupt until the first accepted load.
- R2: A load with `load_req`=1 and `mode_user`=0 (monitor mode) is accepted. At the next clock edge `count_o` takes the value of `load_val` and `irq_o` clears. A tick in the same cycle does not decrement the count.
- R3: A load with `load_req`=1 and `mode_user`=1 (user mode) is rejected. It changes neither `count_o` nor `irq_o`. `priv_err_o` is 1 for the one cycle that follows each such request.
- R4: In a cycle with `tick_en`=1, no accepted load and a count above zero, the count drops by exactly one.
- R5: A count of zero stays at zero when ticks arrive and never wraps to the maximum value.
- R6: After an accepted load of N>0, the N-th tick brings the count to 0. `irq_o` rises at that same edge.
- R7: After an accepted load of zero, `irq_o` rises at the first following tick.
- R8: The interrupt request is raised once per loaded slice, as follows:
  - Once raised, `irq_o` stays high until an `irq_ack` cycle, which clears it at the next edge.
  - If the interrupt is raised in the same cycle as an acknowledge, raising wins and `irq_o` stays high.
  - After an acknowledge, further ticks at zero do not raise it again until the next accepted load.
- R9: `elapsed_o` (32 bits) increases by one at each edge with `tick_en`=1, whatever the mode, load or privilege outcome.
- R10: With `tick_en`=0 and no accepted load, `count_o` and `elapsed_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick, one count step per high cycle |
| mode_user | input | 1 | Processor mode: 0 monitor, 1 user |
| load_req | input | 1 | Request to load the countdown |
| load_val | input | CNT_W | Count to load |
| irq_ack | input | 1 | Acknowledge of the interrupt request |
| count_o | output | CNT_W | Current countdown value |
| irq_o | output | 1 | Time-slice-expired interrupt request (level) |
| priv_err_o | output | 1 | One-cycle pulse for a rejected user-mode load |
| elapsed_o | output | TIME_W | Free-running elapsed-tick count |

## Verification
The hardest state to reach from the ports is the one in which the count sits at zero, the interrupt has already been acknowledged, and ticks keep arriving. Here the timer must stay quiet. A close second is the single cycle in which the expiring tick and an acknowledge arrive together.

The stimulus table loads a count of one, then ticks and acknowledges in the same cycle. It also acknowledges an expired slice and keeps ticking afterwards. A rejected user-mode load is placed on a tick cycle, which shows that the tick still decrements while the load is dropped.

// File: rtl/slice_timer_pkg.sv
// Package: shared types and default widths for the time-slice timer.
// Assumes: consumers import it before use; no state lives here.
package slice_timer_pkg;
    localparam int DEF_CNT_W  = 16;
    localparam int DEF_TIME_W = 32;

    // Outcome of a load request after the privilege check.
    typedef enum logic [1:0] {
        LD_NONE   = 2'd0,
        LD_ACCEPT = 2'd1,
        LD_REJECT = 2'd2
    } ld_kind_e;
endpackage

// File: rtl/st_priv_gate.sv
// Module: st_priv_gate
// Decides whether a load request is honoured (monitor mode) or rejected
// (user mode), and registers a one-cycle violation pulse for rejections.
// Assumes: mode_user is stable for the cycle in which load_req is sampled.
module st_priv_gate
    import slice_timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_req,
    input  logic mode_user,
    output logic ld_accept,
    output logic priv_err
);
    ld_kind_e ld_kind;

    // Classify the current load request.
    always_comb begin
        if (!load_req)     ld_kind = LD_NONE;
        else if (mode_user) ld_kind = LD_REJECT;
        else               ld_kind = LD_ACCEPT;
    end

    assign ld_accept = (ld_kind == LD_ACCEPT);

    // Register the violation pulse for one cycle per rejected request.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_err <= 1'b0;
        else        priv_err <= (ld_kind == LD_REJECT);
    end

    // R3
    err_follows_user_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && mode_user) |=> priv_err);
    // R3
    err_only_after_user_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_req || !mode_user) |=> !priv_err);
endmodule

// File: rtl/st_down_counter.sv
// Module: st_down_counter
// Holds the countdown value and the armed flag. An accepted load sets the
// count and arms the timer; each tick decrements toward zero and saturates.
// Emits zero_event on the tick that expires an armed slice.
// Assumes: ld_accept already reflects the privilege check.
module st_down_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_accept,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] count,
    output logic             zero_event
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic armed;
    logic at_or_near_zero;

    // Flag a count that the next tick leaves at zero.
    assign at_or_near_zero = (count <= ONE);

    // An armed slice expires on the tick that leaves the count at zero.
    assign zero_event = tick && !ld_accept && armed && at_or_near_zero;

    // Load, decrement with saturation, and track whether a slice is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            armed <= 1'b0;
        end else if (ld_accept) begin
            count <= load_val;
            armed <= 1'b1;
        end else if (tick) begin
            if (count != '0) count <= count - ONE;
            if (zero_event)  armed <= 1'b0;
        end
    end

    // R4
    dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_accept && count != '0) |=> (count == $past(count) - ONE));
    // R5
    zero_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_accept && count == '0) |=> (count == '0));
    // R10
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_accept) |=> $stable(count));
    // R2
    load_applies_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_accept |=> (count == $past(load_val)));
endmodule

// File: rtl/st_irq_hold.sv
// Module: st_irq_hold
// Holds the level interrupt request. It is set by an expiry event and
// cleared by an acknowledge or by an accepted reload; a set wins over an
// acknowledge in the same cycle.
// Assumes: set_ev and ld_accept are never high together.
module st_irq_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic ld_accept,
    input  logic ack,
    output logic irq
);
    // Set has priority; ack or reload clears.
    always_ff @(posedge clk) begin
        if (!rst_n)                irq <= 1'b0;
        else if (set_ev)           irq <= 1'b1;
        else if (ld_accept || ack) irq <= 1'b0;
    end

    // R8
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !ack && !ld_accept) |=> irq);
    // R8
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !set_ev) |=> !irq);
    // R2
    reload_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_accept |=> !irq);
endmodule

// File: rtl/st_elapsed.sv
// Module: st_elapsed
// Free-running elapsed-tick counter used as a time base. Advances on every
// tick with no dependence on mode or loads; wraps at its width.
// Assumes: nothing beyond a clean tick input.
module st_elapsed #(
    parameter int TIME_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    output logic [TIME_W-1:0] elapsed
);
    // Count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)    elapsed <= '0;
        else if (tick) elapsed <= elapsed + TIME_W'(1);
    end

    // R9
    tick_advances_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (elapsed == $past(elapsed) + TIME_W'(1)));
    // R10
    no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(elapsed));
endmodule

// File: rtl/slice_timer.sv
// Module: slice_timer (top)
// Privileged time-slice countdown timer: a monitor-mode-only load, a
// saturating down counter with an expiry interrupt, and an elapsed-tick
// time base.
// Assumes: all inputs are synchronous to clk; reset is synchronous, active low.
module slice_timer
    import slice_timer_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int TIME_W = DEF_TIME_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              mode_user,
    input  logic              load_req,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              irq_ack,
    output logic [CNT_W-1:0]  count_o,
    output logic              irq_o,
    output logic              priv_err_o,
    output logic [TIME_W-1:0] elapsed_o
);
    logic ld_accept;
    logic zero_event;

    st_priv_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_req  (load_req),
        .mode_user (mode_user),
        .ld_accept (ld_accept),
        .priv_err  (priv_err_o)
    );

    st_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .ld_accept  (ld_accept),
        .load_val   (load_val),
        .tick       (tick_en),
        .count      (count_o),
        .zero_event (zero_event)
    );

    st_irq_hold u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_ev    (zero_event),
        .ld_accept (ld_accept),
        .ack       (irq_ack),
        .irq       (irq_o)
    );

    st_elapsed #(.TIME_W(TIME_W)) u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .elapsed (elapsed_o)
    );

    // R3
    user_load_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_req && mode_user && !tick_en) |=> $stable(count_o));
    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && !(load_req && !mode_user)) |=> (count_o != {CNT_W{1'b1}} || $past(count_o) != '0));
endmodule

// File: tb/sim_slice_timer.sv
// Bench for slice_timer: a vector table walked by one loop, then directed
// tests for reset, long countdown and exact expiry timing.
module sim_slice_timer;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 16;
    localparam int TW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tick_en, mode_user, load_req, irq_ack;
    logic [CW-1:0] load_val;
    logic [CW-1:0] count_o;
    logic          irq_o, priv_err_o;
    logic [TW-1:0] elapsed_o;

    int checks = 0;
    int errors = 0;
    int ticks_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slice_timer #(.CNT_W(CW), .TIME_W(TW)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .mode_user(mode_user),
        .load_req(load_req), .load_val(load_val), .irq_ack(irq_ack),
        .count_o(count_o), .irq_o(irq_o), .priv_err_o(priv_err_o),
        .elapsed_o(elapsed_o)
    );

    typedef struct packed {
        logic          user;
        logic          ld;
        logic [CW-1:0] val;
        logic          tk;
        logic          ak;
        logic [CW-1:0] ecnt;
        logic          eirq;
        logic          eerr;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 16'd0, 1'b0, 1'b0}, // R5 R1: unarmed tick at zero
        '{1'b0, 1'b1, 16'd3, 1'b0, 1'b0, 16'd3, 1'b0, 1'b0}, // R2 monitor load 3
        '{1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0}, // R4
        '{1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 16'd2, 1'b0, 1'b0}, // R10 idle
        '{1'b1, 1'b1, 16'd9, 1'b1, 1'b0, 16'd1, 1'b0, 1'b1}, // R3 user load on tick
        '{1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 16'd0, 1'b1, 1'b0}, // R6 expiry
        '{1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 16'd0, 1'b1, 1'b0}, // R8 held
        '{1'b0, 1'b0, 16'd0, 1'b0, 1'b1, 16'd0, 1'b0, 1'b0}, // R8 ack
        '{1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 16'd0, 1'b0, 1'b0}, // R8 no re-raise
        '{1'b0, 1'b1, 16'd0, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0}, // R7 load zero
        '{1'b0, 1'b0, 16'd0, 1'b1, 1'b0, 16'd0, 1'b1, 1'b0}, // R7 first tick
        '{1'b0, 1'b1, 16'd5, 1'b1, 1'b0, 16'd5, 1'b0, 1'b0}, // R2 load beats tick
        '{1'b1, 1'b1, 16'd0, 1'b0, 1'b0, 16'd5, 1'b0, 1'b1}, // R3
        '{1'b1, 1'b1, 16'd0, 1'b0, 1'b0, 16'd5, 1'b0, 1'b1}, // R3 repeat
        '{1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 16'd5, 1'b0, 1'b0}, // R3 pulse ends
        '{1'b0, 1'b1, 16'd1, 1'b0, 1'b0, 16'd1, 1'b0, 1'b0}, // R2
        '{1'b0, 1'b0, 16'd0, 1'b1, 1'b1, 16'd0, 1'b1, 1'b0}, // R8 set wins over ack
        '{1'b0, 1'b0, 16'd0, 1'b0, 1'b1, 16'd0, 1'b0, 1'b0}  // R8 ack clears
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of inputs at a falling edge, then wait to the next falling edge.
    task automatic cycle(input logic u, input logic l, input logic [CW-1:0] v,
                         input logic t, input logic a);
        mode_user = u; load_req = l; load_val = v; tick_en = t; irq_ack = a;
        if (t) ticks_seen++;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; tick_en = 0; mode_user = 0; load_req = 0; load_val = '0; irq_ack = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 count", 32'(count_o), 32'd0);
        check("R1 irq", 32'(irq_o), 32'd0);
        check("R1 err", 32'(priv_err_o), 32'd0);
        check("R1 elapsed", elapsed_o, 32'd0);

        for (int i = 0; i < NV; i++) begin
            cycle(VEC[i].user, VEC[i].ld, VEC[i].val, VEC[i].tk, VEC[i].ak);
            check($sformatf("R2/R8 vec%0d count", i), 32'(count_o), 32'(VEC[i].ecnt));
            check($sformatf("R6/R7/R8 vec%0d irq", i), 32'(irq_o), 32'(VEC[i].eirq));
            check($sformatf("R3 vec%0d err", i), 32'(priv_err_o), 32'(VEC[i].eerr));
            check($sformatf("R9 vec%0d elapsed", i), elapsed_o, 32'(ticks_seen));
        end

        // R6: load 3, expiry exactly on the third tick
        cycle(0, 1, 16'd3, 0, 0);
        cycle(0, 0, '0, 1, 0);
        cycle(0, 0, '0, 1, 0);
        check("R6 before expiry irq", 32'(irq_o), 32'd0);
        check("R6 before expiry count", 32'(count_o), 32'd1);
        cycle(0, 0, '0, 1, 0);
        check("R6 at expiry irq", 32'(irq_o), 32'd1);

        // R3: user load while interrupt pending leaves it asserted
        cycle(1, 1, 16'd7, 0, 0);
        check("R3 irq untouched", 32'(irq_o), 32'd1);
        check("R3 count untouched", 32'(count_o), 32'd0);

        // R4: long countdown from the maximum value, elapsed tracks in user mode
        cycle(0, 1, 16'hFFFF, 0, 0);
        for (int k = 0; k < 100; k++) cycle(1, 0, '0, 1, 0);
        check("R4 long countdown", 32'(count_o), 32'(16'hFFFF - 16'd100));
        check("R9 elapsed user mode", elapsed_o, 32'(ticks_seen));

        // R1: reset mid-run
        rst_n = 1'b0;
        cycle(0, 0, '0, 1, 0);
        rst_n = 1'b1;
        ticks_seen = 0;
        check("R1 mid reset count", 32'(count_o), 32'd0);
        check("R1 mid reset elapsed", elapsed_o, 32'd0);
        cycle(0, 0, '0, 1, 0);
        check("R1 disarmed after reset irq", 32'(irq_o), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule